// File: doc/BRIEF.md
# Framed Serial Word Receiver

This block receives four-bit words over a two-wire link: a clock line and a data line, both driven by a remote sender. A local system clock, at least four times faster than the link clock, oversamples both lines through two-flop synchronisers. The block watches for edges on each line. A data-line edge while the link clock is high is a framing event. A falling data edge marks the start of a word, and a rising data edge marks its end. Data bits are taken on rising link-clock edges.

When a word closes correctly, the block presents it on a parallel output and raises a valid strobe for one local cycle. A word that ends too early is a framing error, and so is one followed by too many link-clock pulses before it ends. A framing error gives a one-cycle error pulse, no strobe, and a return to waiting for a start. The output word holds its last good value until the next good word arrives.

Top module: `framed_serial_rx`

## Requirements
- R1: While reset is asserted, and after it is released until the first framing event, `word_o` is 0, `valid_o` is 0 and `frame_err_o` is 0.
- R2: A falling edge on `sda_i` while `scl_i` is high is a start. It is never taken as a data bit, and it is accepted in any state.
- R3: After a start, each rising edge of `scl_i` samples `sda_i` as the next data bit. The first bit sampled goes to `word_o[3]` and the fourth goes to `word_o[0]`.
- R4: A rising edge on `sda_i` while `scl_i` is high, seen after four data bits, loads the word into `word_o` and pulses `valid_o` for exactly one cycle. This happens on the third rising local clock edge after the data-line change, counting the first edge that samples it.
- R5: `word_o` changes only together with a `valid_o` pulse. Framing errors and ignored events leave it unchanged.
- R6: A stop seen after fewer than four data bits pulses `frame_err_o` for one cycle, with the same latency as R4, and does not pulse `valid_o`.
- R7: After the fourth data bit, one further rising edge of `scl_i` is allowed, so that the sender can pull the data line low ahead of the stop. A second such edge before the stop pulses `frame_err_o`, and the stop that follows is then ignored.
- R8: A start that arrives partway through a word discards the partial bits and begins a fresh word. Only the fresh word is reported.
- R9: A rising `sda_i` edge while `scl_i` is high, seen while waiting for a start, has no effect: no strobe, no error, and `word_o` is unchanged.
- R10: `valid_o` and `frame_err_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local system clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| scl_i | input | 1 | Link clock line from the remote sender (idles high) |
| sda_i | input | 1 | Link data line from the remote sender (idles high) |
| word_o | output | 4 | Last correctly framed word, first received bit in bit 3 |
| valid_o | output | 1 | One-cycle strobe when `word_o` is loaded |
| frame_err_o | output | 1 | One-cycle framing-error pulse |

## Verification
Every result is due on the third rising local clock edge after the line change that causes it. Two of those edges pass through the synchroniser stages and the third loads the output register; edge detection adds no register. The bench changes the lines only at falling clock edges and reads the outputs at falling edges. The directed cases check that the strobe and the error pulse are low at the second falling edge after the stop, high at the third, and low again at the fourth. The random frames allow several idle cycles after each stop, then compare the counts of strobes and errors and the last word seen against a model of the framing rules.

// File: rtl/sfrx_pkg.sv
package sfrx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_DATA     = 2'd1,
    ST_TAIL     = 2'd2,
    ST_STOPWAIT = 2'd3
  } rx_state_e;
endpackage

// File: rtl/sfrx_rst_sync.sv
module sfrx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = pipe_q[STAGES-1];
endmodule

// File: rtl/sfrx_line_sync.sv
module sfrx_line_sync #(
  parameter int   STAGES   = 2,
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{IDLE_LVL}};
      prev_q  <= IDLE_LVL;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], line_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;
endmodule

// File: rtl/sfrx_frame_fsm.sv
module sfrx_frame_fsm
  import sfrx_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_lvl_i,
  input  logic              scl_rise_i,
  input  logic              sda_lvl_i,
  input  logic              sda_rise_i,
  input  logic              sda_fall_i,
  output logic [DATA_W-1:0] shift_o,
  output logic              good_o,
  output logic              bad_o
);
  localparam int               CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W - 1);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              start_ev, stop_ev;

  assign start_ev = scl_lvl_i & sda_fall_i;
  assign stop_ev  = scl_lvl_i & sda_rise_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    good_o  = 1'b0;
    bad_o   = 1'b0;
    if (start_ev) begin
      state_d = ST_DATA;
      cnt_d   = '0;
      sh_d    = '0;
    end else if (stop_ev) begin
      unique case (state_q)
        ST_DATA:              bad_o  = 1'b1;
        ST_TAIL, ST_STOPWAIT: good_o = 1'b1;
        default:              ;
      endcase
      state_d = ST_IDLE;
    end else if (scl_rise_i) begin
      unique case (state_q)
        ST_DATA: begin
          sh_d  = {sh_q[DATA_W-2:0], sda_lvl_i};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST) state_d = ST_TAIL;
        end
        ST_TAIL:     state_d = ST_STOPWAIT;
        ST_STOPWAIT: begin
          bad_o   = 1'b1;
          state_d = ST_IDLE;
        end
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
    end
  end

  assign shift_o = sh_q;

  // R8
  restart_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_lvl_i && sda_fall_i) |=> (state_q == ST_DATA && cnt_q == '0));

  // R3
  bit_count_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA) |-> (cnt_q < CNT_W'(DATA_W)));

  // R7
  extra_clock_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOPWAIT && scl_rise_i && !(scl_lvl_i && (sda_rise_i || sda_fall_i)))
      |=> (state_q == ST_IDLE));
endmodule

// File: rtl/sfrx_out_reg.sv
module sfrx_out_reg #(
  parameter int DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] shift_i,
  input  logic              good_i,
  input  logic              bad_i,
  output logic [DATA_W-1:0] word_o,
  output logic              valid_o,
  output logic              err_o
);
  logic [DATA_W-1:0] word_q;
  logic              valid_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (good_i) word_q <= shift_i;
      valid_q <= good_i;
      err_q   <= bad_i;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;

  // R4
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);

  // R6
  err_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> !err_q);

  // R10
  valid_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_q && err_q));

  // R5
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !good_i |=> $stable(word_q));
endmodule

// File: rtl/framed_serial_rx.sv
module framed_serial_rx #(
  parameter int DATA_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic [DATA_W-1:0] word_o,
  output logic              valid_o,
  output logic              frame_err_o
);
  localparam int N_LINES = 2;
  localparam int SCL_IDX = 0;
  localparam int SDA_IDX = 1;

  logic               rst_n;
  logic [N_LINES-1:0] line_in, line_lvl, line_rise, line_fall;
  logic [DATA_W-1:0]  shift;
  logic               good, bad;

  assign line_in = {sda_i, scl_i};

  sfrx_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    sfrx_line_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) i_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_n),
      .line_i  (line_in[g]),
      .level_o (line_lvl[g]),
      .rise_o  (line_rise[g]),
      .fall_o  (line_fall[g])
    );
  end

  sfrx_frame_fsm #(.DATA_W(DATA_W)) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .scl_lvl_i  (line_lvl[SCL_IDX]),
    .scl_rise_i (line_rise[SCL_IDX]),
    .sda_lvl_i  (line_lvl[SDA_IDX]),
    .sda_rise_i (line_rise[SDA_IDX]),
    .sda_fall_i (line_fall[SDA_IDX]),
    .shift_o    (shift),
    .good_o     (good),
    .bad_o      (bad)
  );

  sfrx_out_reg #(.DATA_W(DATA_W)) i_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .shift_i (shift),
    .good_i  (good),
    .bad_i   (bad),
    .word_o  (word_o),
    .valid_o (valid_o),
    .err_o   (frame_err_o)
  );
endmodule

// File: tb/test_framed_serial_rx.sv
module test_framed_serial_rx;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl, sda;
  logic [3:0] word;
  logic       valid, ferr;

  int n_chk = 0;
  int n_fail = 0;
  int vcnt = 0;
  int ecnt = 0;
  logic [3:0] last_w = 4'h0;

  always #5 clk = ~clk;

  framed_serial_rx i_framed_serial_rx (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl),
    .sda_i       (sda),
    .word_o      (word),
    .valid_o     (valid),
    .frame_err_o (ferr)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) begin vcnt++; last_w = word; end
      if (ferr) ecnt++;
    end
  end

  task automatic check(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // frame up to (not including) the stop edge; bits MSB first
  task automatic send_body(logic [3:0] bits, int nbits, int tail, int h);
    scl = 1'b1; sda = 1'b1; wait_cyc(h);
    sda = 1'b0; wait_cyc(h);
    for (int i = 0; i < nbits; i++) begin
      scl = 1'b0; wait_cyc(1);
      sda = bits[3-i]; wait_cyc(h);
      scl = 1'b1; wait_cyc(h);
    end
    for (int t = 0; t < tail; t++) begin
      scl = 1'b0; wait_cyc(1);
      sda = 1'b0; wait_cyc(h);
      scl = 1'b1; wait_cyc(h);
    end
  endtask

  task automatic send(logic [3:0] bits, int nbits, int tail, int h);
    send_body(bits, nbits, tail, h);
    sda = 1'b1; wait_cyc(h);
  endtask

  function automatic bit exp_good(int nbits, int tail);
    return (nbits + tail == 4) || (nbits + tail == 5);
  endfunction

  function automatic logic [3:0] exp_word(logic [3:0] bits, int nbits);
    return bits & (4'hF << (4 - nbits));
  endfunction

  task automatic finish_up();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    int v0, e0;
    logic [3:0] w_exp;
    void'($urandom(32'd1234));
    rst_n = 1'b0; scl = 1'b1; sda = 1'b1;
    wait_cyc(3);
    // R1 reset state
    check("R1", word, 0, "word in reset");
    check("R1", valid, 0, "valid in reset");
    check("R1", ferr, 0, "err in reset");
    rst_n = 1'b1;
    wait_cyc(5);
    check("R1", word, 0, "word after release");

    // R4 exact timing of strobe, R3 bit order
    send_body(4'b1010, 4, 1, 3);
    sda = 1'b1;
    wait_cyc(2); check("R4", valid, 0, "valid two edges after stop");
    wait_cyc(1); check("R4", valid, 1, "valid three edges after stop");
    check("R3", word, 4'hA, "word MSB first");
    wait_cyc(1); check("R4", valid, 0, "valid one cycle only");
    wait_cyc(4);

    // R6 short frame: 2 bits + 1 tail clock = 3 rises
    v0 = vcnt;
    send_body(4'b1100, 2, 1, 3);
    sda = 1'b1;
    wait_cyc(2); check("R6", ferr, 0, "err two edges after stop");
    wait_cyc(1); check("R6", ferr, 1, "err three edges after stop");
    check("R10", valid, 0, "valid with err");
    wait_cyc(1); check("R6", ferr, 0, "err one cycle only");
    wait_cyc(4);
    check("R6", vcnt - v0, 0, "no strobe on short frame");
    check("R5", word, 4'hA, "word held after error");

    // R7 two extra clocks after fourth bit
    v0 = vcnt; e0 = ecnt;
    send(4'b0101, 4, 2, 3); wait_cyc(5);
    check("R7", ecnt - e0, 1, "error on second extra clock");
    check("R7", vcnt - v0, 0, "later stop ignored");
    check("R5", word, 4'hA, "word held after overrun");

    // R4 stop during high phase of last bit (last bit 0, no tail)
    v0 = vcnt;
    send(4'b0110, 4, 0, 3); wait_cyc(5);
    check("R4", vcnt - v0, 1, "stop right after fourth bit");
    check("R4", last_w, 4'h6, "word after direct stop");

    // R8 / R2 restart partway through a word
    v0 = vcnt; e0 = ecnt;
    send_body(4'b1111, 2, 0, 3);
    scl = 1'b0; wait_cyc(1); sda = 1'b1; wait_cyc(3); scl = 1'b1; wait_cyc(3);
    send(4'b1001, 4, 1, 3); wait_cyc(5);
    check("R8", vcnt - v0, 1, "one strobe after restart");
    check("R8", ecnt - e0, 0, "no error after restart");
    check("R2", word, 4'h9, "restart word, start edge not a bit");

    // R9 stop-like edge while idle
    v0 = vcnt; e0 = ecnt;
    scl = 1'b0; wait_cyc(2); sda = 1'b0; wait_cyc(2);
    scl = 1'b1; wait_cyc(3); sda = 1'b1; wait_cyc(6);
    check("R9", vcnt - v0, 0, "no strobe on idle stop");
    check("R9", ecnt - e0, 0, "no error on idle stop");
    check("R9", word, 4'h9, "word unchanged on idle stop");

    // random frames
    for (int k = 0; k < 40; k++) begin
      int r, nb, tl, h;
      logic [3:0] bits;
      r    = int'($urandom % 8);
      nb   = (r < 5) ? 4 : 1 + (r % 3);
      tl   = ($urandom % 4 == 0) ? 2 : 1;
      h    = 2 + int'($urandom % 4);
      bits = 4'($urandom);
      v0 = vcnt; e0 = ecnt; w_exp = word;
      send(bits, nb, tl, h);
      wait_cyc(5);
      if (exp_good(nb, tl)) w_exp = exp_word(bits, nb);
      check("R3", vcnt - v0, exp_good(nb, tl) ? 1 : 0, "random strobe count");
      check("R6", ecnt - e0, exp_good(nb, tl) ? 0 : 1, "random error count");
      check("R5", word, w_exp, "random word");
    end
    finish_up();
  end
endmodule